// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block drives a one-time-programmable fuse macro on behalf of a register front end. A program command supplies a word address, a 32-bit value and a packed timing word. The sequencer first reads the addressed fuse word and removes from the value every bit that is already blown. It then walks the remaining bits from the least significant upward, shifting the working word right with zero fill. Each 1 bit gets a timed burn pulse, framed by guard intervals. A 0 bit is passed over in one cycle.

A reload command reads every fuse word in ascending address order and writes each one into a shadow bank through a simple write port. After a program finishes, the block refuses new commands for a fixed guard time, counted in clock cycles and derived from the clock frequency. A reload is not followed by this guard. `ready` tells the front end when a command will be taken. `done` pulses once as each operation completes.

Top module: `fuse_prog_seq`

## Requirements
- R1: `timing_cfg` is decoded as burn pulse length in bits [11:0], guard length in bits [15:12] and read pulse length in bits [21:16]. Each field holds its cycle count minus one.
- R2: A program first reads the addressed word and burns only the bits set in `cmd_data & ~fuse_word`. The fuse word afterwards equals the old value OR `cmd_data`, and no blown bit is ever pulsed.
- R3: Burn pulses are issued in strictly ascending bit order. `fz_bit` gives the index of the bit being served, and every pulsed bit is a 1 of the masked word.
- R4: Each burn pulse (`fz_strobe` and `fz_prog_en` both high) lasts burn+1 cycles. It has exactly guard+1 cycles of `fz_prog_en` high with `fz_strobe` low directly before it and directly after it.
- R5: A fuse read holds `fz_read_en` and `fz_strobe` high for read+1 cycles per word. `fz_read_en` and `fz_prog_en` are never high together.
- R6: The program ends after bit 31 or as soon as the remaining word is zero. `busy` is then high for exactly (read+1) + E + P*(2*guard+burn+3) cycles. P is the number of masked 1 bits and L is the highest of them. E is 1 when the masked word is zero, 32 when L is 31, and L+2 otherwise. `done` is high for one cycle, with `busy` low, at the end of every operation.
- R7: After a program, `ready` stays low for exactly CLK_MHZ*HOLD_US cycles once `busy` falls. A start pulse during that time has no effect.
- R8: A reload performs NWORDS shadow writes at addresses 0, 1, 2, ... and in that order. Each write carries the fuse word at its address. `ready` returns in the cycle `busy` falls.
- R9: After reset `busy`, `done`, `fz_strobe`, `fz_prog_en`, `fz_read_en` and `sh_we` are low and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Program command pulse, taken when `ready` |
| start_reload | input | 1 | Shadow reload command pulse, taken when `ready` |
| cmd_addr | input | ADDR_W | Fuse word address for a program |
| cmd_data | input | DATA_W | Bits to burn |
| timing_cfg | input | 22 | Packed burn, guard and read lengths |
| busy | output | 1 | Operation in progress |
| ready | output | 1 | Idle and outside the post-program guard time |
| done | output | 1 | One-cycle completion pulse |
| fz_addr | output | ADDR_W | Fuse macro word address |
| fz_bit | output | IDX_W | Fuse macro bit index for burning |
| fz_prog_en | output | 1 | Fuse macro program enable |
| fz_read_en | output | 1 | Fuse macro read enable |
| fz_strobe | output | 1 | Fuse macro strobe |
| fz_rdata | input | DATA_W | Fuse macro read data |
| sh_we | output | 1 | Shadow bank write enable |
| sh_addr | output | ADDR_W | Shadow bank write address |
| sh_wdata | output | DATA_W | Shadow bank write data |

## Verification
A corrupted working word or mask shows up at the ports as a wrong fuse value, or as a pulse on an already blown bit, as soon as the first burn pulse is issued. A bad bit index or a bad timer count shows up on the same pulse, as a pulse width or guard length that differs from the configured field, or as bits served out of order. A wrong end condition changes the total `busy` length, which the bench predicts from the masked data. A holdoff or reload address error appears within one guard time or one word read.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRD,
        S_EVAL,
        S_PRE,
        S_STB,
        S_POST,
        S_RLD
    } seq_state_e;

    // field layout of the packed timing word (MSB first)
    typedef struct packed {
        logic [5:0]  rd_len;
        logic [3:0]  guard_len;
        logic [11:0] burn_len;
    } timing_t;

    localparam int TIM_W = $bits(timing_t);
    localparam int TMR_W = 12;

endpackage

// File: rtl/fps_cycle_timer.sv
module fps_cycle_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fps_shifter.sv
module fps_shifter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          mask_en,
    input  logic [DW-1:0] mask_val,
    input  logic          shift,
    output logic [DW-1:0] word,
    output logic          zero
);
    logic [DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load)
            word_d = load_val;
        else if (mask_en)
            word_d = word_q & ~mask_val;
        else if (shift)
            word_d = {1'b0, word_q[DW-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;
    assign zero = (word_q == '0);

    // R2: bits already blown never survive the mask step
    a_r2_mask_clears_blown: assert property (@(posedge clk) disable iff (!rst_n)
        mask_en && !load |=> (word_q & $past(mask_val)) == '0);

    // R3: right shift brings in a zero at the top
    a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        shift && !load && !mask_en |=> !word_q[DW-1]);

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
    import fps_pkg::*;
#(
    parameter int NWORDS  = 128,
    parameter int DATA_W  = 32,
    parameter int CLK_MHZ = 125,
    parameter int HOLD_US = 2,
    localparam int ADDR_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int IDX_W    = $clog2(DATA_W),
    localparam int POST_CYC = CLK_MHZ * HOLD_US,
    localparam int HOLD_W   = $clog2(POST_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_reload,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [TIM_W-1:0]  timing_cfg,
    output logic              busy,
    output logic              ready,
    output logic              done,
    output logic [ADDR_W-1:0] fz_addr,
    output logic [IDX_W-1:0]  fz_bit,
    output logic              fz_prog_en,
    output logic              fz_read_en,
    output logic              fz_strobe,
    input  logic [DATA_W-1:0] fz_rdata,
    output logic              sh_we,
    output logic [ADDR_W-1:0] sh_addr,
    output logic [DATA_W-1:0] sh_wdata
);
    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        timing_t           tim;
        logic [HOLD_W-1:0] hold;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;
    timing_t cfg_in;
    logic tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic sh_load, sh_mask, sh_shift, sh_zero;
    logic [DATA_W-1:0] sh_word;

    assign cfg_in = timing_t'(timing_cfg);
    assign ready  = (r_q.state == S_IDLE) && (r_q.hold == '0);

    fps_cycle_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp)
    );

    fps_shifter #(.DW(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(cmd_data),
        .mask_en (sh_mask),
        .mask_val(fz_rdata),
        .shift   (sh_shift),
        .word    (sh_word),
        .zero    (sh_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_mask  = 1'b0;
        sh_shift = 1'b0;
        if (r_q.state == S_IDLE && r_q.hold != '0)
            r_d.hold = r_q.hold - HOLD_W'(1);
        unique case (r_q.state)
            S_IDLE: begin
                if (ready && start_prog) begin
                    r_d.state = S_PRD;
                    r_d.addr  = cmd_addr;
                    r_d.tim   = cfg_in;
                    sh_load   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(cfg_in.rd_len);
                end else if (ready && start_reload) begin
                    r_d.state = S_RLD;
                    r_d.addr  = '0;
                    r_d.tim   = cfg_in;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(cfg_in.rd_len);
                end
            end
            S_PRD: begin
                if (tmr_exp) begin
                    sh_mask   = 1'b1;
                    r_d.idx   = '0;
                    r_d.state = S_EVAL;
                end
            end
            S_EVAL: begin
                if (sh_zero) begin
                    r_d.state = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.hold  = HOLD_W'(POST_CYC);
                end else if (sh_word[0]) begin
                    r_d.state = S_PRE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(r_q.tim.guard_len);
                end else begin
                    sh_shift = 1'b1;
                    r_d.idx  = r_q.idx + IDX_W'(1);
                end
            end
            S_PRE: begin
                if (tmr_exp) begin
                    r_d.state = S_STB;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(r_q.tim.burn_len);
                end
            end
            S_STB: begin
                if (tmr_exp) begin
                    r_d.state = S_POST;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(r_q.tim.guard_len);
                end
            end
            S_POST: begin
                if (tmr_exp) begin
                    if (r_q.idx == IDX_W'(DATA_W - 1)) begin
                        r_d.state = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.hold  = HOLD_W'(POST_CYC);
                    end else begin
                        sh_shift  = 1'b1;
                        r_d.idx   = r_q.idx + IDX_W'(1);
                        r_d.state = S_EVAL;
                    end
                end
            end
            S_RLD: begin
                if (tmr_exp) begin
                    if (r_q.addr == ADDR_W'(NWORDS - 1)) begin
                        r_d.state = S_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.addr = r_q.addr + ADDR_W'(1);
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(r_q.tim.rd_len);
                    end
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.state != S_IDLE);
    assign done       = r_q.done;
    assign fz_addr    = r_q.addr;
    assign fz_bit     = r_q.idx;
    assign fz_prog_en = (r_q.state == S_PRE) || (r_q.state == S_STB) || (r_q.state == S_POST);
    assign fz_read_en = (r_q.state == S_PRD) || (r_q.state == S_RLD);
    assign fz_strobe  = (r_q.state == S_STB) || fz_read_en;
    assign sh_we      = (r_q.state == S_RLD) && tmr_exp;
    assign sh_addr    = r_q.addr;
    assign sh_wdata   = fz_rdata;

    // R5: read and program never overlap at the macro
    a_r5_read_prog_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fz_read_en && fz_prog_en));

    // R4: a burn pulse only ever serves a 1 bit of the working word
    a_r4_burn_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        fz_strobe && fz_prog_en |-> sh_word[0]);

    // R7: an operation only starts from the ready condition
    a_r7_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ready));

    // R6: completion pulse is seen with busy low
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/fuse_prog_seq_tb.sv
module fuse_prog_seq_tb;
    localparam int NW   = 8;
    localparam int AW   = 3;
    localparam int POST = 125 * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_prog = 1'b0, start_reload = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [21:0] timing_cfg = '0;
    logic busy, ready, done, fz_prog_en, fz_read_en, fz_strobe, sh_we;
    logic [AW-1:0] fz_addr, sh_addr;
    logic [4:0] fz_bit;
    logic [31:0] fz_rdata, sh_wdata;

    logic [31:0] fz_arr [NW];
    logic pre_en = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [31:0] pre_val = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // expectations written by the tasks, read by the monitor
    int exp_sp = 0, exp_r = 0, exp_rd_run = 0, sh_base = 0;
    logic [31:0] exp_mask = '0;

    // cumulative monitor counters
    int busy_cnt = 0, done_cnt = 0, hold_cnt = 0, strobes = 0;
    int width_err = 0, relax_err = 0, order_err = 0, rd_err = 0, sh_err = 0, sh_cnt = 0;
    int run_stb = 0, gap = 0, run_rd = 0, last_bit = -1;
    logic prev_stbp = 0, prev_pen = 0, prev_ren = 0;

    always #4 clk = ~clk;

    fuse_prog_seq #(.NWORDS(NW), .DATA_W(32), .CLK_MHZ(125), .HOLD_US(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_reload(start_reload),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .timing_cfg(timing_cfg),
        .busy(busy), .ready(ready), .done(done), .fz_addr(fz_addr), .fz_bit(fz_bit),
        .fz_prog_en(fz_prog_en), .fz_read_en(fz_read_en), .fz_strobe(fz_strobe),
        .fz_rdata(fz_rdata), .sh_we(sh_we), .sh_addr(sh_addr), .sh_wdata(sh_wdata)
    );

    assign fz_rdata = fz_arr[fz_addr];

    // behavioural fuse array: a burn strobe sets the addressed bit
    always @(negedge clk) begin
        if (pre_en)
            fz_arr[pre_addr] <= pre_val;
        else if (fz_strobe && fz_prog_en)
            fz_arr[fz_addr][fz_bit] <= 1'b1;
    end

    always @(negedge clk) begin
        logic stbp;
        stbp = fz_strobe && fz_prog_en;
        if (busy) busy_cnt++;
        if (done) done_cnt++;
        if (!busy && !ready) hold_cnt++;
        if (stbp) begin
            if (!prev_stbp) begin
                if (gap != exp_r + 1) relax_err++;
                if (!exp_mask[fz_bit] || int'(fz_bit) <= last_bit) order_err++;
                last_bit = int'(fz_bit);
                strobes++;
                run_stb = 0;
            end
            run_stb++;
        end else if (prev_stbp) begin
            if (run_stb != exp_sp + 1) width_err++;
            gap = 0;
        end
        if (fz_prog_en && !fz_strobe) gap++;
        if (!fz_prog_en && prev_pen) begin
            if (gap != exp_r + 1) relax_err++;
            gap = 0;
        end
        if (fz_read_en) begin
            if (!prev_ren) last_bit = -1;
            run_rd++;
        end else if (prev_ren) begin
            if (run_rd != exp_rd_run) rd_err++;
            run_rd = 0;
        end
        if (sh_we) begin
            if (int'(sh_addr) != sh_cnt - sh_base || sh_wdata != fz_arr[sh_addr]) sh_err++;
            sh_cnt++;
        end
        prev_stbp = stbp;
        prev_pen  = fz_prog_en;
        prev_ren  = fz_read_en;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic preload(input int a, input logic [31:0] v);
        pre_addr = AW'(a);
        pre_val  = v;
        pre_en   = 1'b1;
        step();
        pre_en = 1'b0;
        step();
    endtask

    task automatic do_prog(input int a, input logic [31:0] data, input int sp,
                           input int r, input int sr, input bit poke);
        logic [31:0] old, msk;
        int b0, d0, h0, s0, w0, x0, o0, q0, pc, hi, evals, expb;
        while (!ready) step();
        old = fz_arr[a];
        msk = data & ~old;
        pc  = $countones(msk);
        hi  = -1;
        for (int i = 0; i < 32; i++) if (msk[i]) hi = i;
        evals = (msk == 0) ? 1 : (hi == 31 ? 32 : hi + 2);
        expb  = (sr + 1) + evals + pc * (2 * r + sp + 3);
        exp_sp = sp; exp_r = r; exp_rd_run = sr + 1; exp_mask = msk;
        b0 = busy_cnt; d0 = done_cnt; h0 = hold_cnt; s0 = strobes;
        w0 = width_err; x0 = relax_err; o0 = order_err; q0 = rd_err;
        cmd_addr   = AW'(a);
        cmd_data   = data;
        timing_cfg = {6'(sr), 4'(r), 12'(sp)};   // R1 field layout
        start_prog = 1'b1;
        step();
        start_prog = 1'b0;
        while (done_cnt == d0) step();
        if (poke) begin
            cmd_data   = 32'hFFFF_FFFF;
            start_prog = 1'b1;
            step();
            start_prog = 1'b0;
        end
        while (!ready) step();
        chk(fz_arr[a] == (old | data), "R2 fuse word after program", fz_arr[a], old | data);
        chk(strobes - s0 == pc, "R2 burn pulse count", strobes - s0, pc);
        chk(order_err == o0, "R3 bit order or mask", order_err - o0, 0);
        chk(width_err == w0, "R4 R1 burn pulse width", width_err - w0, 0);
        chk(relax_err == x0, "R4 R1 guard length", relax_err - x0, 0);
        chk(rd_err == q0, "R5 R1 read pulse length", rd_err - q0, 0);
        chk(busy_cnt - b0 == expb, "R6 busy length", busy_cnt - b0, expb);
        chk(done_cnt - d0 == 1, "R6 done pulses", done_cnt - d0, 1);
        chk(hold_cnt - h0 == POST, poke ? "R7 holdoff with ignored start" : "R7 holdoff length",
            hold_cnt - h0, POST);
    endtask

    task automatic do_reload(input int sr);
        int b0, d0, h0, c0, e0, q0;
        while (!ready) step();
        exp_rd_run = NW * (sr + 1);
        sh_base    = sh_cnt;
        b0 = busy_cnt; d0 = done_cnt; h0 = hold_cnt; c0 = sh_cnt; e0 = sh_err; q0 = rd_err;
        timing_cfg   = {6'(sr), 4'd0, 12'd0};
        start_reload = 1'b1;
        step();
        start_reload = 1'b0;
        while (done_cnt == d0) step();
        step();
        step();
        chk(sh_cnt - c0 == NW, "R8 shadow write count", sh_cnt - c0, NW);
        chk(sh_err == e0, "R8 shadow address order and data", sh_err - e0, 0);
        chk(rd_err == q0, "R5 reload read length", rd_err - q0, 0);
        chk(busy_cnt - b0 == NW * (sr + 1), "R8 reload busy length", busy_cnt - b0, NW * (sr + 1));
        chk(hold_cnt == h0 && ready, "R8 no holdoff after reload", hold_cnt - h0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) fz_arr[i] = '0;
        repeat (3) step();
        // R9: state held in reset and just after release
        chk(!busy && ready && !done, "R9 reset status", {busy, ready, done}, 3'b010);
        chk(!fz_strobe && !fz_prog_en && !fz_read_en && !sh_we, "R9 reset macro lines",
            {fz_strobe, fz_prog_en, fz_read_en, sh_we}, 0);
        rst_n = 1'b1;
        step();
        chk(!busy && ready, "R9 after reset release", {busy, ready}, 2'b01);

        do_prog(0, 32'h0000_0001, 3, 1, 2, 0);
        do_prog(1, 32'hFFFF_FFFF, 2, 0, 1, 0);
        do_prog(2, 32'h8000_0000, 5, 2, 4, 0);
        do_prog(3, 32'h0000_0000, 1, 1, 1, 0);
        do_prog(1, 32'hFFFF_FFFF, 1, 1, 1, 0);          // R2 all bits already blown
        preload(4, 32'h0F0F_00FF);
        do_prog(4, 32'hFFFF_0F0F, 2, 3, 3, 1);          // R2 partial overlap, R7 poke
        for (int k = 0; k < 8; k++)
            do_prog(5 + (k % 3), 32'h1 << (k * 4) | 32'h0000_0100 << k, k % 4, k % 3, k, k[0]);
        do_reload(3);
        do_reload(0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule